// File: doc/BRIEF.md
# Circular Rename Register File with Latest-Instance Search

This block is a rename register file for an out-of-order core, kept apart from the architectural registers and run as a ring of entries between a head and a tail pointer. Each instruction that names a destination register claims the entry at the head. The head then moves on, so two writes to the same architectural register always land in different entries. An execution unit later writes its result into the entry whose index it was handed. When the reorder logic retires the oldest instruction, the entry at the tail is copied into the architectural register file and released.

Source operands are found by searching every occupied entry for the architectural register number. No map table is kept. Each entry carries a latest flag, which is set when the entry is claimed and cleared when a younger entry claims the same architectural register. The search therefore hits at most one entry, the newest one. A hit on an entry that holds its result returns that value. A hit on an entry still waiting for its result returns the entry index as a tag. If nothing matches, the value comes from the architectural file and is ready.

The default size is sixteen entries, eight architectural registers, one claim per cycle, one retirement per cycle and two source search ports. Search results are combinational and reflect the state left by earlier clock edges.

Top module: `latest_rename_ring`

## Requirements
- R1: After reset the ring is empty, `alloc_ready` is 1, `retire_ack` is 0 and every architectural register reads as 0 through the search ports with `src_valid` 1.
- R2: When `alloc_req` is high and `alloc_ready` is high, the entry whose index is shown on `alloc_tag` (the head) is claimed at the clock edge. The head then advances by one, modulo the entry count.
- R3: Once every entry is occupied and none has retired, `alloc_ready` is 0 and `alloc_req` claims nothing: the next successful claim after a retirement gets the index of the freed entry.
- R4: A search returns the entry most recently claimed for the given architectural register, even when older occupied entries name the same register.
- R5: A search that hits an entry without a result gives `src_valid` 0, `src_data` 0 and `src_tag` equal to that entry's index.
- R6: A write with `wb_en` high stores `wb_data` into the occupied entry `wb_tag` and marks it ready. Later searches that hit it give `src_valid` 1, that data and the entry's index as tag.
- R7: When an architectural register has both an occupied rename entry and an architectural value, the search returns the rename entry's state, not the architectural value.
- R8: A search that hits no entry returns the architectural register's value with `src_valid` 1 and `src_tag` 0.
- R9: `retire_ack` is 1 only when `retire_req` is high, the ring is not empty and the tail entry holds its result. In that cycle the entry's value is written into the architectural register it names, the entry is released and the tail advances by one.
- R10: Searches see only state from earlier edges: a claim or write in the same cycle does not change the result of that cycle's search, and each search port works independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_req | input | 1 | Request to claim an entry for a destination |
| alloc_areg | input | AREG_W (3) | Architectural destination register number |
| alloc_ready | output | 1 | A free entry exists |
| alloc_tag | output | IDX_W (4) | Index the next claim receives |
| src_areg | input | SRC_PORTS*AREG_W (6) | Architectural source register per search port |
| src_valid | output | SRC_PORTS (2) | Per port: returned value is ready |
| src_data | output | SRC_PORTS*DATA_W (32) | Per port: returned value |
| src_tag | output | SRC_PORTS*IDX_W (8) | Per port: index of the matching entry |
| wb_en | input | 1 | Result write strobe |
| wb_tag | input | IDX_W (4) | Entry receiving the result |
| wb_data | input | DATA_W (16) | Result value |
| retire_req | input | 1 | Request to retire the oldest entry |
| retire_ack | output | 1 | Oldest entry retired this cycle |

## Verification
The bench fills the ring with two instances of every architectural register. A design that resolved by position instead of the latest flag would return the older instance of a register. A design without a full flag would claim over live entries, and the next claim index after a retirement would then be wrong. Retirement is requested while the tail entry is still waiting for its result. A design that ignored readiness would commit a stale value, which then appears in later searches that miss the ring. A long pseudo-random mix of claims, writes, retirements and searches with pointer wrap-around is compared against a model that scans backwards from the head. This exposes missed latest-flag clears and lost architectural updates.

// File: rtl/lrr_pkg.sv
package lrr_pkg;
   typedef struct packed {
      logic busy;
      logic latest;
      logic ready;
   } lrr_flags_t;

   localparam lrr_flags_t LRR_FREE = '{busy: 1'b0, latest: 1'b0, ready: 1'b0};
   localparam lrr_flags_t LRR_FRESH = '{busy: 1'b1, latest: 1'b1, ready: 1'b0};
endpackage

// File: rtl/lrr_ring_ctrl.sv
module lrr_ring_ctrl #(
   parameter int ENTRIES = 16,
   localparam int IDX_W = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc_req,
   input  logic             retire_req,
   input  logic             tail_ready,
   output logic [IDX_W-1:0] head,
   output logic [IDX_W-1:0] tail,
   output logic             full,
   output logic             empty,
   output logic             alloc_fire,
   output logic             retire_fire
);
   logic [IDX_W-1:0] head_nx;
   logic [IDX_W-1:0] tail_nx;

   assign empty       = (head == tail) && !full;
   assign alloc_fire  = alloc_req && !full;
   assign retire_fire = retire_req && !empty && tail_ready;
   assign head_nx     = head + 1'b1;
   assign tail_nx     = tail + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head <= '0;
         tail <= '0;
         full <= 1'b0;
      end else begin
         if (alloc_fire)  head <= head_nx;
         if (retire_fire) tail <= tail_nx;
         if (alloc_fire && !retire_fire && (head_nx == tail))
            full <= 1'b1;
         else if (retire_fire && !alloc_fire)
            full <= 1'b0;
      end
   end
endmodule

// File: rtl/lrr_entry_array.sv
module lrr_entry_array
   import lrr_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int AREG_W  = 3,
   parameter int DATA_W  = 16,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      alloc_fire,
   input  logic [IDX_W-1:0]          alloc_idx,
   input  logic [AREG_W-1:0]         alloc_areg,
   input  logic                      wb_en,
   input  logic [IDX_W-1:0]          wb_idx,
   input  logic [DATA_W-1:0]         wb_data,
   input  logic                      retire_fire,
   input  logic [IDX_W-1:0]          retire_idx,
   output logic [ENTRIES-1:0]        busy_vec,
   output logic [ENTRIES-1:0]        latest_vec,
   output logic [ENTRIES-1:0]        ready_vec,
   output logic [ENTRIES*AREG_W-1:0] areg_flat,
   output logic [ENTRIES*DATA_W-1:0] data_flat,
   output logic                      tail_ready,
   output logic [AREG_W-1:0]         tail_areg,
   output logic [DATA_W-1:0]         tail_data
);
   lrr_flags_t        flags_q [ENTRIES];
   logic [AREG_W-1:0] areg_q  [ENTRIES];
   logic [DATA_W-1:0] data_q  [ENTRIES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) begin
            flags_q[i] <= LRR_FREE;
            areg_q[i]  <= '0;
            data_q[i]  <= '0;
         end
      end else begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (retire_fire && (retire_idx == IDX_W'(i))) begin
               flags_q[i] <= LRR_FREE;
            end else if (alloc_fire && (alloc_idx == IDX_W'(i))) begin
               flags_q[i] <= LRR_FRESH;
               areg_q[i]  <= alloc_areg;
               data_q[i]  <= '0;
            end else begin
               if (alloc_fire && flags_q[i].busy && (areg_q[i] == alloc_areg))
                  flags_q[i].latest <= 1'b0;
               if (wb_en && (wb_idx == IDX_W'(i)) && flags_q[i].busy) begin
                  flags_q[i].ready <= 1'b1;
                  data_q[i]        <= wb_data;
               end
            end
         end
      end
   end

   for (genvar g = 0; g < ENTRIES; g++) begin : g_flat
      assign busy_vec[g]                     = flags_q[g].busy;
      assign latest_vec[g]                   = flags_q[g].latest;
      assign ready_vec[g]                    = flags_q[g].ready;
      assign areg_flat[g*AREG_W +: AREG_W]   = areg_q[g];
      assign data_flat[g*DATA_W +: DATA_W]   = data_q[g];
   end

   assign tail_ready = flags_q[retire_idx].ready;
   assign tail_areg  = areg_q[retire_idx];
   assign tail_data  = data_q[retire_idx];
endmodule

// File: rtl/lrr_arch_file.sv
module lrr_arch_file #(
   parameter int ARCH_REGS = 8,
   parameter int DATA_W    = 16,
   parameter int RD_PORTS  = 2,
   localparam int AREG_W   = $clog2(ARCH_REGS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [AREG_W-1:0]          wr_addr,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic [RD_PORTS*AREG_W-1:0] rd_addr,
   output logic [RD_PORTS*DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] regs_q [ARCH_REGS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ARCH_REGS; i++) regs_q[i] <= '0;
      end else if (wr_en) begin
         regs_q[wr_addr] <= wr_data;
      end
   end

   for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
      assign rd_data[p*DATA_W +: DATA_W] = regs_q[rd_addr[p*AREG_W +: AREG_W]];
   end
endmodule

// File: rtl/lrr_lookup.sv
module lrr_lookup #(
   parameter int ENTRIES = 16,
   parameter int AREG_W  = 3,
   parameter int DATA_W  = 16,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic [ENTRIES-1:0]        busy_vec,
   input  logic [ENTRIES-1:0]        latest_vec,
   input  logic [ENTRIES-1:0]        ready_vec,
   input  logic [ENTRIES*AREG_W-1:0] areg_flat,
   input  logic [ENTRIES*DATA_W-1:0] data_flat,
   input  logic [AREG_W-1:0]         src_areg,
   input  logic [DATA_W-1:0]         arch_data,
   output logic                      src_valid,
   output logic [DATA_W-1:0]         src_data,
   output logic [IDX_W-1:0]          src_tag
);
   logic [ENTRIES-1:0] match;
   logic [DATA_W-1:0]  hit_data;
   logic [IDX_W-1:0]   hit_tag;
   logic               hit_ready;
   logic               hit;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match[g] = busy_vec[g] && latest_vec[g] &&
                        (areg_flat[g*AREG_W +: AREG_W] == src_areg);
   end

   always_comb begin
      hit_data  = '0;
      hit_tag   = '0;
      hit_ready = 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
         hit_data  = hit_data | ({DATA_W{match[i]}} & data_flat[i*DATA_W +: DATA_W]);
         hit_tag   = hit_tag  | ({IDX_W{match[i]}} & IDX_W'(i));
         hit_ready = hit_ready | (match[i] & ready_vec[i]);
      end
   end

   assign hit       = |match;
   assign src_valid = hit ? hit_ready : 1'b1;
   assign src_data  = hit ? hit_data  : arch_data;
   assign src_tag   = hit ? hit_tag   : '0;
endmodule

// File: rtl/latest_rename_ring.sv
module latest_rename_ring #(
   parameter int ENTRIES   = 16,
   parameter int ARCH_REGS = 8,
   parameter int DATA_W    = 16,
   parameter int SRC_PORTS = 2,
   localparam int IDX_W    = $clog2(ENTRIES),
   localparam int AREG_W   = $clog2(ARCH_REGS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        alloc_req,
   input  logic [AREG_W-1:0]           alloc_areg,
   output logic                        alloc_ready,
   output logic [IDX_W-1:0]            alloc_tag,
   input  logic [SRC_PORTS*AREG_W-1:0] src_areg,
   output logic [SRC_PORTS-1:0]        src_valid,
   output logic [SRC_PORTS*DATA_W-1:0] src_data,
   output logic [SRC_PORTS*IDX_W-1:0]  src_tag,
   input  logic                        wb_en,
   input  logic [IDX_W-1:0]            wb_tag,
   input  logic [DATA_W-1:0]           wb_data,
   input  logic                        retire_req,
   output logic                        retire_ack
);
   initial begin
      assert (ENTRIES >= 2 && (ENTRIES & (ENTRIES - 1)) == 0)
         else $error("ENTRIES must be a power of two of at least 2");
      assert (ARCH_REGS >= 2 && (ARCH_REGS & (ARCH_REGS - 1)) == 0)
         else $error("ARCH_REGS must be a power of two of at least 2");
      assert (DATA_W >= 1 && SRC_PORTS >= 1)
         else $error("DATA_W and SRC_PORTS must be positive");
   end

   logic [IDX_W-1:0]            head;
   logic [IDX_W-1:0]            tail;
   logic                        full;
   logic                        empty;
   logic                        alloc_fire;
   logic                        retire_fire;
   logic                        tail_ready;
   logic [AREG_W-1:0]           tail_areg;
   logic [DATA_W-1:0]           tail_data;
   logic [ENTRIES-1:0]          busy_vec;
   logic [ENTRIES-1:0]          latest_vec;
   logic [ENTRIES-1:0]          ready_vec;
   logic [ENTRIES*AREG_W-1:0]   areg_flat;
   logic [ENTRIES*DATA_W-1:0]   data_flat;
   logic [SRC_PORTS*DATA_W-1:0] arch_rd;

   lrr_ring_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .alloc_req   (alloc_req),
      .retire_req  (retire_req),
      .tail_ready  (tail_ready),
      .head        (head),
      .tail        (tail),
      .full        (full),
      .empty       (empty),
      .alloc_fire  (alloc_fire),
      .retire_fire (retire_fire)
   );

   lrr_entry_array #(.ENTRIES(ENTRIES), .AREG_W(AREG_W), .DATA_W(DATA_W)) u_entries (
      .clk         (clk),
      .rst_n       (rst_n),
      .alloc_fire  (alloc_fire),
      .alloc_idx   (head),
      .alloc_areg  (alloc_areg),
      .wb_en       (wb_en),
      .wb_idx      (wb_tag),
      .wb_data     (wb_data),
      .retire_fire (retire_fire),
      .retire_idx  (tail),
      .busy_vec    (busy_vec),
      .latest_vec  (latest_vec),
      .ready_vec   (ready_vec),
      .areg_flat   (areg_flat),
      .data_flat   (data_flat),
      .tail_ready  (tail_ready),
      .tail_areg   (tail_areg),
      .tail_data   (tail_data)
   );

   lrr_arch_file #(.ARCH_REGS(ARCH_REGS), .DATA_W(DATA_W), .RD_PORTS(SRC_PORTS)) u_arch (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (retire_fire),
      .wr_addr (tail_areg),
      .wr_data (tail_data),
      .rd_addr (src_areg),
      .rd_data (arch_rd)
   );

   for (genvar p = 0; p < SRC_PORTS; p++) begin : g_port
      lrr_lookup #(.ENTRIES(ENTRIES), .AREG_W(AREG_W), .DATA_W(DATA_W)) u_lookup (
         .busy_vec   (busy_vec),
         .latest_vec (latest_vec),
         .ready_vec  (ready_vec),
         .areg_flat  (areg_flat),
         .data_flat  (data_flat),
         .src_areg   (src_areg[p*AREG_W +: AREG_W]),
         .arch_data  (arch_rd[p*DATA_W +: DATA_W]),
         .src_valid  (src_valid[p]),
         .src_data   (src_data[p*DATA_W +: DATA_W]),
         .src_tag    (src_tag[p*IDX_W +: IDX_W])
      );
   end

   assign alloc_ready = !full;
   assign alloc_tag   = head;
   assign retire_ack  = retire_fire;
endmodule

// File: rtl/lrr_checker.sv
module lrr_checker #(
   parameter int ENTRIES = 16,
   parameter int AREG_W  = 3,
   localparam int IDX_W  = $clog2(ENTRIES),
   localparam int NAREG  = 1 << AREG_W
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      alloc_fire,
   input logic                      retire_fire,
   input logic                      full,
   input logic [IDX_W-1:0]          head,
   input logic [IDX_W-1:0]          tail,
   input logic                      wb_en,
   input logic [IDX_W-1:0]          wb_tag,
   input logic [ENTRIES-1:0]        busy_vec,
   input logic [ENTRIES-1:0]        latest_vec,
   input logic [ENTRIES-1:0]        ready_vec,
   input logic [ENTRIES*AREG_W-1:0] areg_flat
);
   // R3: a full ring without a retirement keeps its head
   assert_full_holds_head_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !retire_fire) |=> $stable(head));

   // R2: each claim moves the head by one
   assert_head_steps_R2: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_fire |=> (head == IDX_W'($past(head) + 1'b1)));

   // R9: each retirement moves the tail by one and frees the entry
   assert_tail_steps_R9: assert property (@(posedge clk) disable iff (!rst_n)
      retire_fire |=> ((tail == IDX_W'($past(tail) + 1'b1)) && !busy_vec[$past(tail)]));

   // R6: a result write to an occupied entry leaves it ready
   assert_wb_marks_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_en && busy_vec[wb_tag] && !(retire_fire && (wb_tag == tail)))
         |=> ready_vec[$past(wb_tag)]);

   // R4: latest flags sit only on occupied entries
   assert_latest_on_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((latest_vec & ~busy_vec) == '0));

   for (genvar a = 0; a < NAREG; a++) begin : g_areg
      logic [ENTRIES-1:0] same;
      for (genvar e = 0; e < ENTRIES; e++) begin : g_e
         assign same[e] = (areg_flat[e*AREG_W +: AREG_W] == AREG_W'(a));
      end
      // R4: at most one latest instance per architectural register
      assert_single_latest_R4: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(latest_vec & busy_vec & same));
   end
endmodule

bind latest_rename_ring lrr_checker #(.ENTRIES(ENTRIES), .AREG_W(AREG_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .alloc_fire  (alloc_fire),
   .retire_fire (retire_fire),
   .full        (full),
   .head        (head),
   .tail        (tail),
   .wb_en       (wb_en),
   .wb_tag      (wb_tag),
   .busy_vec    (busy_vec),
   .latest_vec  (latest_vec),
   .ready_vec   (ready_vec),
   .areg_flat   (areg_flat)
);

// File: tb/latest_rename_ring_tb.sv
`timescale 1ns/1ps
module latest_rename_ring_tb;
   localparam int N  = 16;
   localparam int NA = 8;
   localparam int DW = 16;
   localparam int IW = 4;
   localparam int AW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic alloc_req = 1'b0;
   logic [AW-1:0] alloc_areg = '0;
   logic alloc_ready;
   logic [IW-1:0] alloc_tag;
   logic [2*AW-1:0] src_areg = '0;
   logic [1:0] src_valid;
   logic [2*DW-1:0] src_data;
   logic [2*IW-1:0] src_tag;
   logic wb_en = 1'b0;
   logic [IW-1:0] wb_tag = '0;
   logic [DW-1:0] wb_data = '0;
   logic retire_req = 1'b0;
   logic retire_ack;

   always #2.5 clk = ~clk;

   latest_rename_ring u_dut (
      .clk(clk), .rst_n(rst_n),
      .alloc_req(alloc_req), .alloc_areg(alloc_areg),
      .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
      .src_areg(src_areg), .src_valid(src_valid),
      .src_data(src_data), .src_tag(src_tag),
      .wb_en(wb_en), .wb_tag(wb_tag), .wb_data(wb_data),
      .retire_req(retire_req), .retire_ack(retire_ack)
   );

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   // reference model
   bit m_busy [N];
   bit m_valid [N];
   int m_areg [N];
   int m_data [N];
   int m_arch [NA];
   int m_head = 0;
   int m_tail = 0;
   int m_cnt = 0;

   task automatic check(input string req, input int got, input int exp);
      checks++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
      end
   endtask

   // newest occupied entry for a register, scanning back from the head
   task automatic expect_lookup(input int areg, output int v, output int d, output int t);
      v = 1; d = m_arch[areg]; t = 0;
      for (int k = 1; k <= m_cnt; k++) begin
         int idx;
         idx = (m_head - k + N) % N;
         if (m_busy[idx] && m_areg[idx] == areg) begin
            v = m_valid[idx] ? 1 : 0;
            d = m_valid[idx] ? m_data[idx] : 0;
            t = idx;
            break;
         end
      end
   endtask

   task automatic cycle(input bit a_req, input int a_reg, input bit w_en, input int w_tag,
                        input int w_data, input bit r_req, input int s0, input int s1,
                        input string lreq);
      int ev, ed, et;
      bit ret, aok;
      int old_tail;
      alloc_req  = a_req;
      alloc_areg = AW'(a_reg);
      wb_en      = w_en;
      wb_tag     = IW'(w_tag);
      wb_data    = DW'(w_data);
      retire_req = r_req;
      src_areg   = {AW'(s1), AW'(s0)};
      #1;
      check("R3 alloc_ready", int'(alloc_ready), (m_cnt < N) ? 1 : 0);
      check("R2 alloc_tag", int'(alloc_tag), m_head);
      ret = r_req && (m_cnt > 0) && m_valid[m_tail];
      check("R9 retire_ack", int'(retire_ack), ret ? 1 : 0);
      for (int p = 0; p < 2; p++) begin
         expect_lookup((p == 0) ? s0 : s1, ev, ed, et);
         check({lreq, " src_valid"}, int'(src_valid[p]), ev);
         check({lreq, " src_data"}, int'(src_data[p*DW +: DW]), ed);
         check({lreq, " src_tag"}, int'(src_tag[p*IW +: IW]), et);
      end
      aok = a_req && (m_cnt < N);
      @(posedge clk);
      old_tail = m_tail;
      if (ret) begin
         m_arch[m_areg[m_tail]] = m_data[m_tail];
         m_busy[m_tail] = 0;
         m_valid[m_tail] = 0;
         m_tail = (m_tail + 1) % N;
         m_cnt--;
      end
      if (w_en && m_busy[w_tag] && !(ret && w_tag == old_tail)) begin
         m_valid[w_tag] = 1;
         m_data[w_tag] = w_data & 16'hFFFF;
      end
      if (aok) begin
         m_busy[m_head] = 1;
         m_valid[m_head] = 0;
         m_areg[m_head] = a_reg;
         m_data[m_head] = 0;
         m_head = (m_head + 1) % N;
         m_cnt++;
      end
      @(negedge clk);
   endtask

   initial begin
      for (int i = 0; i < N; i++) begin
         m_busy[i] = 0; m_valid[i] = 0; m_areg[i] = 0; m_data[i] = 0;
      end
      for (int i = 0; i < NA; i++) m_arch[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 / R8: reset state, all registers come from the architectural file
      for (int a = 0; a < NA; a += 2) cycle(0, 0, 0, 0, 0, 1, a, a + 1, "R1");

      // R2 / R4 / R10: fill the ring, two instances of every register;
      // each search asks for the register being claimed in the same cycle
      for (int i = 0; i < N; i++) cycle(1, i % NA, 0, 0, 0, 0, i % NA, (i + 3) % NA, "R10");

      // R3: full ring refuses claims; R5: latest instances are unready
      cycle(1, 5, 0, 0, 0, 0, 0, 1, "R5");
      cycle(1, 6, 0, 0, 0, 0, 2, 3, "R5");
      for (int a = 0; a < NA; a += 2) cycle(0, 0, 0, 0, 0, 0, a, a + 1, "R4");

      // R6 / R7: results into older and newer instances of register 0
      cycle(0, 0, 1, 0, 100, 0, 0, 0, "R7");
      cycle(0, 0, 1, 8, 108, 0, 0, 0, "R7");
      cycle(0, 0, 0, 0, 0, 0, 0, 1, "R6");

      // R9: tail ready -> retire; next tail not ready -> refused
      cycle(0, 0, 0, 0, 0, 1, 0, 1, "R9");
      cycle(1, 7, 0, 0, 0, 1, 1, 0, "R9");
      cycle(1, 7, 0, 0, 0, 0, 7, 0, "R3");

      // results for the rest, then drain the ring completely
      for (int i = 1; i < N; i++) if (i != 8) cycle(0, 0, 1, i, 200 + i, 0, i % NA, 0, "R6");
      cycle(0, 0, 1, 0, 300, 0, 7, 0, "R6");
      for (int i = 0; i < N + 2; i++) cycle(0, 0, 0, 0, 0, 1, i % NA, (i + 5) % NA, "R8");
      for (int a = 0; a < NA; a += 2) cycle(0, 0, 0, 0, 0, 0, a, a + 1, "R8");

      // pseudo-random mix with wrap-around
      begin
         logic [31:0] lfsr;
         lfsr = 32'h1ACE_B00C;
         for (int n = 0; n < 3000; n++) begin
            int wt;
            bit we;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            we = 0; wt = 0;
            for (int k = 0; k < N; k++) begin
               int idx;
               idx = (int'(lfsr[19:16]) + k) % N;
               if (!we && m_busy[idx] && !m_valid[idx]) begin
                  we = lfsr[6] | lfsr[13];
                  wt = idx;
               end
            end
            cycle(lfsr[0] | lfsr[1], int'(lfsr[4:2]), we, wt, int'(lfsr[31:20]) + n,
                  lfsr[5] | lfsr[14], int'(lfsr[9:7]), int'(lfsr[12:10]), "R4");
         end
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #500000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule